// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a memory port and an instruction consumer and keeps a small store of instruction bytes ready ahead of demand. While the consumer is busy, the block issues two-byte fetches to a request/response memory port. It places the returned bytes into a six-entry byte FIFO, so that the consumer can take its next byte without waiting on memory. Bytes are handed out one per handshake in address order.

Fetching begins at a start address sampled while reset is held. The queue is refilled only in pairs. A new fetch is issued only when at least two slots are free and no other fetch is pending, which means a returning response always has room. When the consumer redirects its flow, a flush empties the queue, reloads the fetch address from a supplied target, and discards any response still owed by memory for the old stream.

Top module: `pfq_top`

## Requirements
- R1: While reset is held, `qEmpty` is 1 and `byteValid` and `qFull` are 0. The first request after reset carries `startAddr`.
- R2: Bytes reach the consumer in first-in, first-out order. Within a response, `memRspData[7:0]` is the byte at the request address and `memRspData[15:8]` is the byte at the address plus one, so the consumer sees consecutive addresses.
- R3: `memReqValid` is asserted only when at least two byte slots are free and no flush is being requested.
- R4: At most one fetch is outstanding. After a request handshake, `memReqValid` stays low until the response has returned.
- R5: `memReqAddr` equals the fetch address counter. The counter advances by two after each accepted response and holds steady while a request waits for `memReqReady`.
- R6: A cycle with `flushReq` high leaves the queue empty on the next cycle. The next request then carries `flushAddr`.
- R7: A response for a fetch issued before a flush is discarded. This applies whether it arrives during the flush cycle or later, and no new request is issued until that response has returned.
- R8: A byte pop and an accepted response in the same cycle change the occupancy by exactly +1.
- R9: `qFull` is 1 exactly when six bytes are held, and no request is issued while the queue is full.
- R10: `byteValid` is 1 exactly when the queue is not empty, and `qEmpty` is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startAddr | input | ADDR_W | Fetch address loaded while in reset |
| flushReq | input | 1 | Empty the queue and redirect fetching |
| flushAddr | input | ADDR_W | New fetch address used with flushReq |
| memReqValid | output | 1 | Fetch request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Address of the two-byte fetch |
| memRspValid | input | 1 | Response data valid (always accepted) |
| memRspData | input | 16 | Two bytes, lower address in bits 7:0 |
| byteValid | output | 1 | A byte is available to the consumer |
| byteData | output | 8 | Oldest byte in the queue |
| byteReady | input | 1 | Consumer takes the byte |
| qFull | output | 1 | Six bytes are held |
| qEmpty | output | 1 | No bytes are held |

## Verification
The bench targets the following corner cases:
- A flush issued while a fetch is still in memory. A design that lets the stale response through would hand the consumer bytes from the abandoned address.
- A response arriving in the same cycle as a flush. This case catches designs that clear state without dropping the data.
- A full queue with a stalled consumer. A block that ignored the two-slot rule would overwrite unread bytes.
- A simultaneous pop and push near the boundaries. This exposes occupancy arithmetic that forgets one of the two events.
- Odd flush targets and random memory latency. These check that the address counter and byte order stay aligned.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;   // write two response bytes, advance fetch address
    logic pop;    // consumer took the oldest byte
    logic flush;  // clear pointers, reload fetch address
  } pfqStrobes_t;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushReq,
  input  logic             byteReady,
  input  logic             memReqReady,
  input  logic             memRspValid,
  output logic             memReqValid,
  output logic             qFull,
  output logic             qEmpty,
  output logic [CNT_W-1:0] occ,
  output pfqStrobes_t      strobes
);
  logic outstanding;
  logic stale;
  logic reqFire;

  always_comb begin
    strobes.flush = flushReq;
    strobes.pop   = byteReady && (occ != '0) && !flushReq;
    strobes.push  = memRspValid && !stale && !flushReq;
    memReqValid   = !outstanding && !flushReq && (occ <= CNT_W'(DEPTH - 2));
    reqFire       = memReqValid && memReqReady;
    qFull         = (occ == CNT_W'(DEPTH));
    qEmpty        = (occ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ         <= '0;
      outstanding <= 1'b0;
      stale       <= 1'b0;
    end else if (flushReq) begin
      occ         <= '0;
      outstanding <= outstanding && !memRspValid;
      stale       <= outstanding && !memRspValid;
    end else begin
      occ <= occ + (strobes.push ? CNT_W'(2) : CNT_W'(0))
                 - (strobes.pop ? CNT_W'(1) : CNT_W'(0));
      if (memRspValid) begin
        outstanding <= 1'b0;
        stale       <= 1'b0;
      end else if (reqFire) begin
        outstanding <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfq_data.sv
module pfq_data
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic [15:0]       rspData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [7:0]        byteData
);
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] wrPtrHi;
  logic [7:0]       slots [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wrPtrHi  = bump(wrPtr);
  assign byteData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      fetchAddr <= startAddr;
    end else if (strobes.flush) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      fetchAddr <= flushAddr;
    end else begin
      if (strobes.push) begin
        wrPtr     <= bump(wrPtrHi);
        fetchAddr <= fetchAddr + ADDR_W'(2);
      end
      if (strobes.pop) rdPtr <= bump(rdPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.push && !strobes.flush) begin
        if (wrPtr == PTR_W'(i))        slots[i] <= rspData[7:0];
        else if (wrPtrHi == PTR_W'(i)) slots[i] <= rspData[15:8];
      end
    end
  end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [15:0]       memRspData,
  output logic              byteValid,
  output logic [7:0]        byteData,
  input  logic              byteReady,
  output logic              qFull,
  output logic              qEmpty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  pfqStrobes_t      strobes;
  logic [CNT_W-1:0] occ;

  pfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .byteReady(byteReady),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memReqValid(memReqValid), .qFull(qFull), .qEmpty(qEmpty),
    .occ(occ), .strobes(strobes)
  );

  pfq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startAddr(startAddr),
    .flushAddr(flushAddr), .rspData(memRspData), .fetchAddr(memReqAddr),
    .byteData(byteData)
  );

  assign byteValid = !qEmpty;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushReq,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              byteValid,
  input logic              qFull,
  input logic              qEmpty,
  input logic [CNT_W-1:0]  occ
);
  p_room_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (occ <= CNT_W'(DEPTH - 2)) && !flushReq);

  p_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> flushReq || (memReqValid && $stable(memReqAddr)));

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> qEmpty);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));

  p_full_stops_r9: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> !memReqValid && byteValid);

  p_empty_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    qEmpty != byteValid);
endmodule

bind pfq_top pfq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .flushReq(flushReq), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .byteValid(byteValid),
  .qFull(qFull), .qEmpty(qEmpty), .occ(occ)
);

// File: tb/tb_pfq_top.sv
`timescale 1ns/1ps
module tb_pfq_top;
  localparam int DEPTH = 6;
  localparam int AW    = 16;
  localparam logic [AW-1:0] START = 16'h1F3E;

  logic clk = 0;
  logic rstN = 0;
  logic [AW-1:0] startAddr = START;
  logic flushReq = 0;
  logic [AW-1:0] flushAddr = '0;
  logic memReqValid, memReqReady = 0;
  logic [AW-1:0] memReqAddr;
  logic memRspValid = 0;
  logic [15:0] memRspData = '0;
  logic byteValid, byteReady = 0, qFull, qEmpty;
  logic [7:0] byteData;

  always #2.5 clk = ~clk;

  pfq_top #(.DEPTH(DEPTH), .ADDR_W(AW)) dut (.*);

  int compared = 0, mismatched = 0;
  int occM = 0;
  logic [AW-1:0] expAddr = START, fetchM = START, memAddr = '0;
  bit memPending = 0, stale = 0;
  int memLat = 0, forceLat = -1, bothCount = 0;
  bit done = 0;

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd13 + a[15:8] + 8'h29);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int popPct, input int flushPct, input int readyPct);
    bit expReqV, pop, push, rspFire, reqFire;
    @(negedge clk);
    byteReady   = ($urandom % 100) < popPct;
    flushReq    = ($urandom % 100) < flushPct;
    flushAddr   = AW'($urandom);
    memReqReady = ($urandom % 100) < readyPct;
    memRspValid = memPending && (memLat == 0);
    memRspData  = memRspValid ? {memByte(memAddr + 1), memByte(memAddr)} : 16'($urandom);
    #1;
    check(qEmpty == (occM == 0), "R10 qEmpty", qEmpty, occM == 0);
    check(byteValid == (occM != 0), "R10 byteValid", byteValid, occM != 0);
    check(qFull == (occM == DEPTH), "R9 qFull", qFull, occM == DEPTH);
    if (occM != 0) check(byteData == memByte(expAddr), "R2 byte order", byteData, memByte(expAddr));
    expReqV = !memPending && (occM <= DEPTH - 2) && !flushReq;
    check(memReqValid == expReqV, "R3/R4 request gate", memReqValid, expReqV);
    if (expReqV) check(memReqAddr == fetchM, "R5 request address", memReqAddr, fetchM);
    // model update at the coming edge
    rspFire = memRspValid;
    reqFire = memReqValid && memReqReady;
    if (flushReq) begin
      occM = 0; expAddr = flushAddr; fetchM = flushAddr;
      stale = memPending && !rspFire;               // R7
      if (rspFire) memPending = 0;
    end else begin
      pop  = byteReady && occM != 0;
      push = rspFire && !stale;
      if (pop && push) bothCount++;                 // R8
      occM = occM + (push ? 2 : 0) - (pop ? 1 : 0);
      if (pop) expAddr = expAddr + 1;
      if (push) fetchM = fetchM + 2;
      if (rspFire) begin memPending = 0; stale = 0; end
    end
    if (memPending && memLat > 0) memLat--;
    if (reqFire) begin
      memPending = 1; memAddr = memReqAddr;
      memLat = (forceLat >= 0) ? forceLat : int'($urandom % 4);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(qEmpty == 1, "R1 reset qEmpty", qEmpty, 1);
    check(byteValid == 0, "R1 reset byteValid", byteValid, 0);
    check(qFull == 0, "R1 reset qFull", qFull, 0);
    rstN = 1;
    #1;
    check(memReqValid == 1, "R1 first request", memReqValid, 1);
    check(memReqAddr == START, "R1 start address", memReqAddr, START);
    // directed: fill with stalled consumer
    repeat (30) step(0, 0, 100);
    check(qFull == 1, "R9 full after fill", qFull, 1);
    check(memReqValid == 0, "R9 no request when full", memReqValid, 0);
    // directed: drain
    repeat (10) step(100, 0, 100);
    // directed: flush with a fetch left in memory (R7, R6)
    forceLat = 3;
    step(0, 100, 0);
    step(0, 0, 100);
    step(0, 100, 0);
    check(memPending == 1 && stale == 1, "R7 stale pending in model", stale, 1);
    repeat (6) step(0, 0, 0);
    check(qEmpty == 1, "R7 stale response dropped", qEmpty, 1);
    forceLat = 0;
    step(0, 0, 100);
    step(50, 100, 0);   // response coincides with a flush
    forceLat = -1;
    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int popP = (ph % 4) * 30 + 5;
      int flP  = (ph % 3 == 0) ? 0 : 4;
      for (int c = 0; c < 400; c++) step(popP, flP, 70);
    end
    check(bothCount > 0, "R8 pop and push together seen", bothCount, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule